// File: doc/BRIEF.md
# Variable-Width Sum-of-Products Array

This block is the programmable logic plane of a small registered-output logic device. It takes a set of dedicated input signals and one feedback signal per output. Each array input is offered to every product term in both true and inverted form. Each product term is the AND of the literals its connection mask selects.

The ten outputs are grouped in five pairs, and the pairs receive 8, 10, 12, 14 and 16 logic product terms, so the widest outputs can hold twice as many terms as the narrowest. Each output's logic terms are ORed into one sum term. Each output also owns one extra term that serves only as its output enable. Two further terms act as a reset condition and a preset condition shared by every registered output.

The connection masks sit in configuration registers. Software loads them one product term per clock through an address, data and write-enable port, and can read any of them back. The array itself is purely combinational. Macrocell registers and pin drivers live outside this block.

Top module: `pla_sop_array`

## Requirements
- R1: Output pair p (outputs 2p and 2p+1) owns 8+2p logic terms. The logic terms of output k take consecutive addresses starting at the summed term counts of outputs 0..k-1, which covers addresses 0..119. The enable term of output k is at address 120+k, the reset term is at 130 and the preset term is at 131.
- R2: Array input i is bit i of {fb_in, ded_in}, so ded_in takes inputs 0..11 and fb_in takes inputs 12..21. Mask bit 2i connects input i true and mask bit 2i+1 connects it inverted. An enabled term is the AND of its connected literals, and a term with an empty mask is 1.
- R3: Bit 44 of a configuration word is a kill bit. When it is set, the term is 0 whatever its mask holds.
- R4: sum_out[k] is the OR of the logic terms of output k, and it is 0 when all of them are killed.
- R5: oe_out[k] follows only the enable term of output k.
- R6: areset_term follows term 130 and spreset_term follows term 131.
- R7: A write with cfg_we high at a rising edge and cfg_addr below 132 stores cfg_wdata in that entry. A write to any address of 132 or above changes no entry.
- R8: cfg_rdata shows, combinationally, the entry at cfg_addr. It reads 0 for addresses of 132 or above.
- R9: A synchronous active-low reset loads every entry with the kill bit set and an empty mask, so every output is 0.
- R10: All outputs follow input changes in the same cycle, with no clocked latency.
- R11: An enabled term that connects both polarities of one input is 0 for either value of that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| ded_in | input | 12 | Dedicated array inputs |
| fb_in | input | 10 | Feedback inputs, one per output |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Product-term address for write and read |
| cfg_wdata | input | 45 | Kill bit and connection mask to store |
| cfg_rdata | output | 45 | Stored word at cfg_addr |
| sum_out | output | 10 | Sum term per output |
| oe_out | output | 10 | Output-enable term per output |
| areset_term | output | 1 | Shared reset term |
| spreset_term | output | 1 | Shared preset term |

## Verification
The assertions assume that the address, data and strobe are held steady across each clock edge. They also assume that no other agent touches the configuration between a write and the checks that follow it. The stimulus meets both conditions by changing configuration signals only on the falling edge and by keeping a write strobe to one cycle. Random masks are kept sparse, with zero to three literals each and an occasional kill bit. This keeps the sums away from being stuck at 0 or 1, so the OR logic and the literal polarity are both exercised in each direction. The stimulus also includes directed writes to the shared terms, to the widest output's last term, to both polarities of one input and to an address outside the range.

// File: rtl/pla_sop_pkg.sv
// Package pla_sop_pkg
// Purpose: helper functions for the uneven term allocation of the array.
// Assumes: outputs come in pairs; pair p owns base + step*p logic terms.
package pla_sop_pkg;

    // Number of logic product terms owned by output k.
    function automatic int pt_count(input int k, input int base, input int step);
        return base + step * (k / 2);
    endfunction

    // First term address of output k (sum of the counts of outputs below k).
    function automatic int pt_base(input int k, input int base, input int step);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) begin
            acc += pt_count(j, base, step);
        end
        return acc;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
// Module pla_cfg_store
// Purpose: holds one configuration word per product term, written one word
//          per cycle and read back combinationally.
// Assumes: cfg_addr may exceed the entry count; such writes are dropped and
//          such reads return zero. Reset is synchronous and active low.
module pla_cfg_store #(
    parameter int N_TERMS = 132,
    parameter int W       = 45,
    parameter int AW      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [AW-1:0]               cfg_addr,
    input  logic [W-1:0]                cfg_wdata,
    output logic [W-1:0]                cfg_rdata,
    output logic [N_TERMS-1:0][W-1:0]   term_words
);

    localparam logic [W-1:0]  RST_WORD = {1'b1, {(W-1){1'b0}}};
    localparam logic [AW-1:0] LAST_OK  = AW'(N_TERMS - 1);

    logic [N_TERMS-1:0][W-1:0] mem;
    logic                      addr_ok;

    // Decode whether the address names an existing entry.
    assign addr_ok = (cfg_addr <= LAST_OK);

    // Load reset words or store the addressed word on a valid write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERMS; t++) begin
                mem[t] <= RST_WORD;
            end
        end else if (cfg_we && addr_ok) begin
            mem[cfg_addr] <= cfg_wdata;
        end
    end

    // Present the addressed word, or zero outside the map.
    always_comb begin
        cfg_rdata = '0;
        if (addr_ok) begin
            cfg_rdata = mem[cfg_addr];
        end
    end

    assign term_words = mem;

    // R7: a valid write is found in the addressed entry one edge later.
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && addr_ok) |=> (mem[$past(cfg_addr)] == $past(cfg_wdata)));

    // R8: without a write, a steady address reads a steady word.
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we) && $stable(cfg_addr)) |-> $stable(cfg_rdata));

endmodule

// File: rtl/pla_pterm.sv
// Module pla_pterm
// Purpose: one product term, the AND of every literal its mask selects.
// Assumes: an empty mask yields 1; the kill bit overrides everything to 0.
module pla_pterm #(
    parameter int N_LIT = 44
) (
    input  logic [N_LIT-1:0] lits,
    input  logic [N_LIT-1:0] mask,
    input  logic             kill,
    output logic             term
);

    // Unconnected literals count as 1; killed terms are forced low.
    assign term = !kill && (&(lits | ~mask));

endmodule

// File: rtl/pla_sum_or.sv
// Module pla_sum_or
// Purpose: OR of the product terms owned by one output.
// Assumes: the caller slices the right term range for the output.
module pla_sum_or #(
    parameter int N = 8
) (
    input  logic [N-1:0] terms,
    output logic         sum
);

    // Any active term drives the sum high.
    assign sum = |terms;

endmodule

// File: rtl/pla_sop_array.sv
// Module pla_sop_array
// Purpose: programmable AND-OR array with ten unevenly sized sum outputs,
//          one enable term per output and two shared control terms.
// Assumes: array inputs are {fb_in, ded_in}; literal 2i is input i true and
//          literal 2i+1 is input i inverted. Term map: logic terms of each
//          output in ascending output order, then enables, reset, preset.
module pla_sop_array #(
    parameter int  N_DED      = 12,
    parameter int  N_PAIRS    = 5,
    parameter int  BASE_TERMS = 8,
    parameter int  STEP_TERMS = 2,
    localparam int N_OUT      = 2 * N_PAIRS,
    localparam int N_IN       = N_DED + N_OUT,
    localparam int N_LIT      = 2 * N_IN,
    localparam int W          = N_LIT + 1,
    localparam int N_LOGIC    = pla_sop_pkg::pt_base(N_OUT, BASE_TERMS, STEP_TERMS),
    localparam int N_TERMS    = N_LOGIC + N_OUT + 2,
    localparam int AW         = $clog2(N_TERMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_OUT-1:0] fb_in,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [W-1:0]     cfg_wdata,
    output logic [W-1:0]     cfg_rdata,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] oe_out,
    output logic             areset_term,
    output logic             spreset_term
);

    localparam int OE_BASE = N_LOGIC;
    localparam int AR_IDX  = N_LOGIC + N_OUT;
    localparam int SP_IDX  = AR_IDX + 1;

    logic [N_IN-1:0]                in_vec;
    logic [N_LIT-1:0]               lits;
    logic [N_TERMS-1:0][W-1:0]      term_words;
    logic [N_TERMS-1:0][N_LIT-1:0]  term_mask;
    logic [N_TERMS-1:0]             term_kill;
    logic [N_TERMS-1:0]             pt;

    // Gather the array inputs, dedicated ones at the low indices.
    assign in_vec = {fb_in, ded_in};

    // Offer each input in true and inverted form.
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = in_vec[i];
        assign lits[2*i+1] = ~in_vec[i];
    end

    pla_cfg_store #(
        .N_TERMS (N_TERMS),
        .W       (W),
        .AW      (AW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .term_words (term_words)
    );

    // Split each stored word into its mask and kill bit, then evaluate.
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        assign term_mask[t] = term_words[t][N_LIT-1:0];
        assign term_kill[t] = term_words[t][W-1];

        pla_pterm #(.N_LIT(N_LIT)) u_pt (
            .lits (lits),
            .mask (term_mask[t]),
            .kill (term_kill[t]),
            .term (pt[t])
        );
    end

    // Build one OR per output over its own slice of logic terms.
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int LB = pla_sop_pkg::pt_base(k, BASE_TERMS, STEP_TERMS);
        localparam int LC = pla_sop_pkg::pt_count(k, BASE_TERMS, STEP_TERMS);

        pla_sum_or #(.N(LC)) u_or (
            .terms (pt[LB +: LC]),
            .sum   (sum_out[k])
        );

        assign oe_out[k] = pt[OE_BASE + k];

        // R4: with every logic term of this output killed, its sum is low.
        p_all_killed_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (&term_kill[LB +: LC]) |-> !sum_out[k]);

        // R3: a killed enable term keeps the enable low.
        p_oe_killed_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            term_kill[OE_BASE + k] |-> !oe_out[k]);
    end

    assign areset_term  = pt[AR_IDX];
    assign spreset_term = pt[SP_IDX];

    // R2: an enabled reset term with no connections is always high.
    p_empty_term_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_kill[AR_IDX] && (term_mask[AR_IDX] == '0)) |-> areset_term);

    // R11: a preset term that uses both polarities of input 0 stays low.
    p_both_pol_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (term_mask[SP_IDX][1:0] == 2'b11) |-> !spreset_term);

endmodule

// File: tb/pla_sop_array_test.sv
module pla_sop_array_test;

    localparam int NT = 132;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [44:0] cfg_wdata = '0;
    logic [44:0] cfg_rdata;
    logic [9:0]  sum_out, oe_out;
    logic        areset_term, spreset_term;

    int errors = 0;
    int checks = 0;
    logic [44:0] shadow [NT];

    pla_sop_array uut (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sum_out(sum_out), .oe_out(oe_out),
        .areset_term(areset_term), .spreset_term(spreset_term)
    );

    always #10 clk = ~clk;

    function automatic int cnt_of(input int k);
        return 8 + 2 * (k / 2);
    endfunction

    function automatic int base_of(input int k);
        int b;
        b = 0;
        for (int j = 0; j < k; j++) b += cnt_of(j);
        return b;
    endfunction

    function automatic logic term_exp(input int t, input logic [21:0] iv);
        logic [44:0] w;
        w = shadow[t];
        if (w[44]) return 1'b0;
        for (int i = 0; i < 22; i++) begin
            if (w[2*i] && !iv[i]) return 1'b0;
            if (w[2*i+1] && iv[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [9:0] sum_exp(input logic [21:0] iv);
        logic [9:0] s;
        s = '0;
        for (int k = 0; k < 10; k++)
            for (int t = base_of(k); t < base_of(k) + cnt_of(k); t++)
                if (term_exp(t, iv)) s[k] = 1'b1;
        return s;
    endfunction

    function automatic logic [9:0] oe_exp(input logic [21:0] iv);
        logic [9:0] s;
        for (int k = 0; k < 10; k++) s[k] = term_exp(120 + k, iv);
        return s;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [44:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < NT) shadow[a] = d;
    endtask

    task automatic apply_and_check(input logic [21:0] iv, input string req);
        {fb_in, ded_in} = iv;
        #1;
        chk(req, 64'(sum_out), 64'(sum_exp(iv)));
        chk(req, 64'(oe_out), 64'(oe_exp(iv)));
        chk(req, 64'(areset_term), 64'(term_exp(130, iv)));
        chk(req, 64'(spreset_term), 64'(term_exp(131, iv)));
    endtask

    function automatic logic [44:0] sparse_word();
        logic [44:0] w;
        w = '0;
        repeat ($urandom_range(0, 3)) w[$urandom_range(0, 43)] = 1'b1;
        w[44] = ($urandom_range(0, 4) == 0);
        return w;
    endfunction

    initial begin
        int seed;
        logic [21:0] iv;
        int t;
        seed = $urandom(32'd1234);
        for (int i = 0; i < NT; i++) shadow[i] = {1'b1, 44'd0};

        // R9: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 sums", 64'(sum_out), 64'd0);
        chk("R9 enables", 64'(oe_out), 64'd0);
        chk("R9 shared", 64'({areset_term, spreset_term}), 64'd0);
        cfg_addr = 8'd0; #1;
        chk("R9 word0", 64'(cfg_rdata), 64'({1'b1, 44'd0}));
        cfg_addr = 8'd131; #1;
        chk("R9 word131", 64'(cfg_rdata), 64'({1'b1, 44'd0}));
        cfg_addr = 8'd200; #1;
        chk("R8 out of range read", 64'(cfg_rdata), 64'd0);

        // R2 R6: enabled empty reset term is high
        wr(8'd130, 45'd0);
        apply_and_check(22'h155AA, "R2 R6 empty term");
        chk("R6 reset term", 64'(areset_term), 64'd1);

        // R11: both polarities of input 0 on preset term
        wr(8'd131, 45'h3);
        apply_and_check(22'h000001, "R11 in0=1");
        apply_and_check(22'h000000, "R11 in0=0");
        chk("R11 preset low", 64'(spreset_term), 64'd0);

        // R3: kill bit overrides empty mask
        wr(8'd130, {1'b1, 44'd0});
        apply_and_check(22'h3FFFFF, "R3 kill");

        // R1 R10: last term of widest output follows ded_in[0] with no latency
        wr(8'd119, 45'h1);
        wr(8'd129, 45'h2);
        apply_and_check(22'h000001, "R1 R10 in0=1");
        chk("R1 out9 high", 64'(sum_out), 64'h200);
        chk("R5 oe9 low", 64'(oe_out), 64'h000);
        apply_and_check(22'h000000, "R1 R10 in0=0");
        chk("R5 oe9 high", 64'(oe_out), 64'h200);

        // R7: out-of-range write changes nothing
        wr(8'd140, 45'd0);
        for (int a = 0; a < NT; a++) begin
            cfg_addr = 8'(a); #1;
            chk("R7 ignored write", 64'(cfg_rdata), 64'(shadow[a]));
        end
        apply_and_check(22'h000001, "R7 outputs unchanged");

        // R4: killing all terms of output 9 forces it low
        wr(8'd119, {1'b1, 44'h1});
        apply_and_check(22'h000001, "R4 all killed");

        // Random full configuration, then mixed updates
        for (int a = 0; a < NT; a++) wr(8'(a), sparse_word());
        for (int r = 0; r < 40; r++) begin
            t = $urandom_range(0, NT - 1);
            wr(8'(t), sparse_word());
            cfg_addr = 8'(t); #1;
            chk("R7 R8 readback", 64'(cfg_rdata), 64'(shadow[t]));
            for (int v = 0; v < 20; v++) begin
                iv = 22'($urandom);
                apply_and_check(iv, "R4 R5 R6 R10 random");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule